// File: doc/BRIEF.md
# Auxiliary External Interrupt Controller

This block adds two active-low external interrupt channels to a microcontroller core. Each channel owns four bits of a single 8-bit control/status register: a trigger-type select, a pending flag, an enable and a priority bit. Software reaches the register in two ways. A byte write at SFR address 0xC0 replaces the whole register. A single-bit set/clear at bit addresses 0xC0 to 0xC7 changes one bit. The register value is always presented on the read port.

The pin inputs arrive already synchronized. Each channel samples its pin once per clock. It catches either a falling edge or a low level, depending on its type bit. A channel raises a request when its flag and its enable are both set, and marks the request high priority when its priority bit is set. The core's vector logic returns a one-cycle acknowledge per channel, and that acknowledge clears a latched edge flag.

Top module: `aux_extint`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, the register reads 0x00 and no request or priority output is high.
- R2: Register layout from bit 0 upward: type A, flag A, enable A, priority A, type B, flag B, enable B, priority B. A byte write with address 0xC0 loads all eight bits on the next clock. A byte write to any other address leaves the register unchanged.
- R3: A bit write with bit address 0xC0+k (k = 0..7) loads bit k with the supplied value and leaves the other bits unchanged. A bit address outside 0xC0..0xC7 has no effect.
- R4: When a byte write and a bit write hit the register in the same cycle, the byte write alone takes effect.
- R5: With type = 1 (edge mode), a pin that was high at the previous clock and is low at the current clock sets the channel's flag at that clock.
- R6: In edge mode the flag stays set once set, whatever the pin does, until an acknowledge or a software write clears it.
- R7: In edge mode an acknowledge pulse for the channel clears its flag on that clock.
- R8: If an edge is detected in the same cycle as an acknowledge or a software clear of the flag, the flag ends up set.
- R9: With type = 0 (level mode), the flag takes the inverted pin value at every clock. Software writes and acknowledges to that flag do not persist beyond that clock.
- R10: Request output n is high exactly when flag n and enable n are both set. Priority output n is high exactly when request n is high and priority bit n is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_addr | input | 8 | Byte write address |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Current register value |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address of the single-bit write |
| bit_val | input | 1 | Value for the single-bit write (1 = set, 0 = clear) |
| pin_a | input | 1 | Synchronized active-low input, channel A |
| pin_b | input | 1 | Synchronized active-low input, channel B |
| irq_ack | input | 2 | Acknowledge pulses, bit 0 channel A, bit 1 channel B |
| irq_req | output | 2 | Pending requests, bit 0 channel A, bit 1 channel B |
| irq_hi | output | 2 | High-priority qualifier for each request |

## Verification
Two events can meet on one clock: a falling edge that sets an edge-mode flag, and an acknowledge or a software clear of the same flag. Directed steps line up a high-to-low pin step with an acknowledge pulse, and then with a flag-clearing bit write, on the same edge. The random phase keeps pins, acknowledges and writes independent, so the same collisions also occur at random. In every case the bench expects the flag to read set on the next cycle, with the request following if the channel is enabled.

// File: rtl/aux_extint.sv
module aux_extint #(
  parameter logic [7:0] REG_ADDR = 8'hC0,
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sfr_wr,
  input  logic [7:0]    sfr_addr,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  input  logic          bit_wr,
  input  logic [7:0]    bit_addr,
  input  logic          bit_val,
  input  logic          pin_a,
  input  logic          pin_b,
  input  logic [CH-1:0] irq_ack,
  output logic [CH-1:0] irq_req,
  output logic [CH-1:0] irq_hi
);
  localparam int W = 4 * CH;

  logic [W-1:0]  ctl, sw, nxt;
  logic [CH-1:0] pin_q, pins, fall, flag_hit;

  assign pins = {pin_b, pin_a};

  wire hit_byte = sfr_wr && (sfr_addr == REG_ADDR);
  wire hit_bit  = bit_wr && (bit_addr[7:3] == REG_ADDR[7:3]);

  always_comb begin
    sw = ctl;
    if (hit_byte) sw = sfr_wdata;
    else if (hit_bit) sw[bit_addr[2:0]] = bit_val;
  end

  for (genvar n = 0; n < CH; n++) begin : g_ch
    localparam int B = 4 * n;
    assign fall[n]     = pin_q[n] & ~pins[n];
    assign flag_hit[n] = hit_byte | (hit_bit && bit_addr[2:0] == 3'(B + 1));
    assign nxt[B]      = sw[B];
    assign nxt[B+2]    = sw[B+2];
    assign nxt[B+3]    = sw[B+3];
    assign nxt[B+1]    = !ctl[B] ? ~pins[n]
                       : fall[n] | (flag_hit[n] ? sw[B+1] : (irq_ack[n] ? 1'b0 : ctl[B+1]));
    assign irq_req[n]  = ctl[B+1] & ctl[B+2];
    assign irq_hi[n]   = irq_req[n] & ctl[B+3];

    // R5
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[B] && pin_q[n] && !pins[n]) |=> ctl[B+1]);
    // R9
    level_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[B] |=> (ctl[B+1] == !$past(pins[n])));
    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[B] && irq_ack[n] && !(pin_q[n] && !pins[n]) && !hit_byte && !hit_bit) |=> !ctl[B+1]);
    // R10
    hi_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi[n] |-> irq_req[n]);
  end

  // R3
  bit_enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && bit_addr == REG_ADDR + 8'd2 && !(sfr_wr && sfr_addr == REG_ADDR))
      |=> (ctl[2] == $past(bit_val)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl   <= '0;
      pin_q <= '1;
    end else begin
      ctl   <= nxt;
      pin_q <= pins;
    end
  end

  assign sfr_rdata = ctl;
endmodule

// File: tb/aux_extint_test.sv
module aux_extint_test;
  logic clk = 0, rst_n = 0;
  logic sfr_wr = 0, bit_wr = 0, bit_val = 0, pin_a = 1, pin_b = 1;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, bit_addr = 0;
  logic [1:0] irq_ack = 0;
  logic [7:0] sfr_rdata;
  logic [1:0] irq_req, irq_hi;

  int checks = 0, errors = 0;
  logic [7:0] m_reg = 0;
  logic [1:0] m_pq = 2'b11;

  always #10 clk = ~clk;

  aux_extint uut (.clk, .rst_n, .sfr_wr, .sfr_addr, .sfr_wdata, .sfr_rdata,
    .bit_wr, .bit_addr, .bit_val, .pin_a, .pin_b, .irq_ack, .irq_req, .irq_hi);

  function automatic logic [7:0] model_next(input logic [7:0] r, input logic [1:0] pq,
                                            input logic [1:0] p);
    logic [7:0] s = r;
    logic [7:0] o;
    logic wb = sfr_wr && sfr_addr == 8'hC0;
    logic wbit = bit_wr && bit_addr >= 8'hC0 && bit_addr <= 8'hC7;
    if (wb) s = sfr_wdata;                       // R2, R4
    else if (wbit) s[bit_addr[2:0]] = bit_val;   // R3
    o = s;
    for (int n = 0; n < 2; n++) begin
      logic touched = wb || (wbit && bit_addr[2:0] == 3'(4*n+1));
      if (!r[4*n]) o[4*n+1] = !p[n];                                  // R9
      else if (pq[n] && !p[n]) o[4*n+1] = 1'b1;                       // R5, R8
      else if (touched) o[4*n+1] = s[4*n+1];
      else if (irq_ack[n]) o[4*n+1] = 1'b0;                           // R7
      else o[4*n+1] = r[4*n+1];                                       // R6
    end
    return o;
  endfunction

  function automatic logic [1:0] exp_req(input logic [7:0] r);
    return {r[5] & r[6], r[1] & r[2]};
  endfunction

  function automatic logic [1:0] exp_hi(input logic [7:0] r);
    return exp_req(r) & {r[7], r[3]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    m_reg = model_next(m_reg, m_pq, {pin_b, pin_a});
    m_pq = {pin_b, pin_a};
    @(negedge clk);
    sfr_wr = 0; bit_wr = 0; irq_ack = 0;
    chk({tag, " reg"}, sfr_rdata, m_reg);
    chk({tag, " R10 req"}, {6'd0, irq_req}, {6'd0, exp_req(m_reg)});
    chk({tag, " R10 hi"}, {6'd0, irq_hi}, {6'd0, exp_hi(m_reg)});
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
  endtask

  task automatic bitw(input logic [7:0] a, input logic v);
    bit_wr = 1; bit_addr = a; bit_val = v;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset reg", sfr_rdata, 8'h00);
    chk("R1 reset req", {6'd0, irq_req, irq_hi[0], irq_hi[1]}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", sfr_rdata, 8'h00);

    bwrite(8'hC0, 8'hDD); cyc("R2 byte write");
    chk("R2 literal", sfr_rdata, 8'hDD);
    bwrite(8'hC1, 8'h00); cyc("R2 other addr ignored");
    chk("R2 literal keep", sfr_rdata, 8'hDD);
    bitw(8'hC3, 1'b0); cyc("R3 clear bit3");
    chk("R3 literal", sfr_rdata, 8'hD5);
    bitw(8'hC8, 1'b0); cyc("R3 out-of-range ignored");
    chk("R3 literal keep", sfr_rdata, 8'hD5);
    bwrite(8'hC0, 8'h55); bitw(8'hC7, 1'b1); cyc("R4 byte wins");
    chk("R4 literal", sfr_rdata, 8'h55);

    pin_a = 0; cyc("R5 fall sets flag");
    chk("R5 flag", {7'd0, sfr_rdata[1]}, 8'd1);
    pin_a = 1; cyc("R6 flag holds");
    chk("R6 flag", {7'd0, sfr_rdata[1]}, 8'd1);
    irq_ack = 2'b01; cyc("R7 ack clears");
    chk("R7 flag", {7'd0, sfr_rdata[1]}, 8'd0);
    pin_a = 0; irq_ack = 2'b01; cyc("R8 edge vs ack");
    chk("R8 flag ack", {7'd0, sfr_rdata[1]}, 8'd1);
    pin_a = 1; irq_ack = 2'b01; cyc("R7 clear again");
    pin_a = 0; bitw(8'hC1, 1'b0); cyc("R8 edge vs clear");
    chk("R8 flag clear", {7'd0, sfr_rdata[1]}, 8'd1);
    chk("R10 req A", {6'd0, irq_req}, 8'd1);

    pin_a = 1; bwrite(8'hC0, 8'h60); cyc("R9 level mode");
    pin_b = 0; cyc("R9 pin low");
    chk("R9 flag B", {7'd0, sfr_rdata[5]}, 8'd1);
    bitw(8'hC5, 1'b0); irq_ack = 2'b10; cyc("R9 no latch");
    chk("R9 flag kept by pin", {7'd0, sfr_rdata[5]}, 8'd1);
    pin_b = 1; cyc("R9 pin high");
    chk("R9 flag B clear", {7'd0, sfr_rdata[5]}, 8'd0);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) pin_a = ~pin_a;
      if ($urandom_range(3) == 0) pin_b = ~pin_b;
      if ($urandom_range(7) == 0) bwrite($urandom_range(1) ? 8'hC0 : 8'($urandom), 8'($urandom));
      if ($urandom_range(3) == 0) bitw(8'hBE + 8'($urandom_range(11)), 1'($urandom));
      irq_ack = 2'($urandom_range(3));
      cyc("R2/R3/R5/R6/R7/R8/R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule